// File: doc/BRIEF.md
# Multi-Zone Bus Cycle Timing Controller

This block shapes every CPU bus cycle according to the address zone it targets. A request strobe with a 17-bit address and a direction flag is decoded into one of several zones: program flash, on-chip RAM, data EEPROM, peripheral space, or unmapped. From the zone, the direction and the configuration fields, the block computes how many idle, wait and hold cycles the access needs. It then steps through them while holding a busy flag high.

Each bus cycle runs in a fixed phase order: optional idle cycles, one access cycle, wait cycles, then hold cycles. Idle cycles are only inserted where consecutive accesses change zone. A configurable setting on the program flash zone can ask for an idle cycle before or after its accesses. Peripheral accesses always get one leading idle cycle. The controller remembers the zone of the previous access and whether that access requested a trailing idle.

Configuration fields are sampled when a request is accepted. They may change freely while the controller is busy.

Top module: `bct_bus_timer`

## Requirements
- R1: `zone_o` reports the zone of the current or last access. The codes are: 0 none (after reset), 1 program flash (0x00000–0x0BFFF and 0x1C000–0x1FFFF), 2 RAM (0x0E000–0x0EFFF), 3 data EEPROM (0x0F000–0x0F27F), 4 peripheral (0x0F800–0x0FAFF and 0x0FC00–0x0FFFF), 5 unmapped (every other address).
- R2: A program flash read with fast read off takes `cfg_wait_i`+1 wait cycles, followed by `cfg_hold_i` hold cycles.
- R3: A program flash read with fast read on takes only its access cycle, whatever the wait and hold fields hold.
- R4: A program flash write with fast read on takes exactly one wait cycle and no hold cycle.
- R5: A program flash write with fast read off takes `cfg_wait_i`+1 wait cycles when `cfg_early_wr_i`=0, or `cfg_wait_i`+2 when it is 1, followed by `cfg_hold_i` hold cycles.
- R6: RAM reads and writes take only their access cycle, whatever the configuration.
- R7: Data EEPROM accesses take one wait cycle when `cfg_eep_zero_ws_i`=0 and none when it is 1, and never take a hold cycle.
- R8: Every peripheral access takes one idle cycle before its access cycle and one wait cycle after it, with no hold.
- R9: A program flash access accepted with `cfg_pre_idle_i`=1 gets one leading idle cycle when the previous access went to a different zone, and none when it went to the same zone.
- R10: When a program flash access was accepted with `cfg_post_idle_i`=1, one idle cycle is added before the next access if that access targets a different zone. This idle cycle adds to any pre-idle of the new access, so up to two idle cycles can occur.
- R11: An unmapped access takes only its access cycle and still becomes the previous zone for the zone-change test.
- R12: `busy_o` rises on the cycle after a request is accepted and stays high through the last phase cycle. Exactly one phase strobe is high per busy cycle, in the order idle, access, wait, hold. Requests arriving while busy are ignored.
- R13: After reset `busy_o` and all phase strobes are low and `zone_o` is 0. The first access after reset never gets an idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_i | input | 1 | Bus cycle request strobe |
| addr_i | input | 17 | Access address |
| wr_i | input | 1 | 1 = write, 0 = read |
| cfg_wait_i | input | 3 | Program flash wait field |
| cfg_hold_i | input | 2 | Program flash hold field |
| cfg_fast_rd_i | input | 1 | Program flash fast read enable |
| cfg_post_idle_i | input | 1 | Program flash trailing idle enable |
| cfg_pre_idle_i | input | 1 | Program flash leading idle enable |
| cfg_early_wr_i | input | 1 | 1 = early write, 0 = late write |
| cfg_eep_zero_ws_i | input | 1 | Data EEPROM zero-wait select |
| busy_o | output | 1 | High while an accepted access is in progress |
| ph_idle_o | output | 1 | Idle phase strobe |
| ph_access_o | output | 1 | Access phase strobe |
| ph_wait_o | output | 1 | Wait phase strobe |
| ph_hold_o | output | 1 | Hold phase strobe |
| zone_o | output | 3 | Decoded zone of the current or last access |

## Verification
A request is accepted on the first rising edge at which it is seen with the controller not busy. The first phase strobe and `busy_o` appear one cycle later. One strobe follows per cycle, and `busy_o` falls on the cycle after the final hold, wait or access cycle. The bench drives on falling edges, drops the request one cycle after raising it, and then samples on every falling edge until busy falls. It tallies idle, access, wait and hold cycles and checks their order. These tallies are compared with counts derived from the zone, the direction, the configuration and the zone of the previous access. Because the previous zone carries over, the bench runs the scenarios in a fixed order and works out each expected idle count from that order.

// File: rtl/bct_pkg.sv
package bct_pkg;

  typedef enum logic [2:0] {
    ZN_NONE     = 3'd0,
    ZN_FLASH    = 3'd1,
    ZN_RAM      = 3'd2,
    ZN_EEP      = 3'd3,
    ZN_PERIPH   = 3'd4,
    ZN_UNMAPPED = 3'd5
  } zone_e;

  typedef enum logic [2:0] {
    PH_READY  = 3'd0,
    PH_GAP    = 3'd1,
    PH_ACCESS = 3'd2,
    PH_WAIT   = 3'd3,
    PH_HOLD   = 3'd4
  } phase_e;

endpackage

// File: rtl/bct_zone_decode.sv
module bct_zone_decode
  import bct_pkg::*;
#(
  parameter int ADDR_W        = 17,
  parameter int FLASH_LO_BASE = 'h00000,
  parameter int FLASH_LO_TOP  = 'h0BFFF,
  parameter int FLASH_HI_BASE = 'h1C000,
  parameter int FLASH_HI_TOP  = 'h1FFFF,
  parameter int RAM_BASE      = 'h0E000,
  parameter int RAM_TOP       = 'h0EFFF,
  parameter int EEP_BASE      = 'h0F000,
  parameter int EEP_TOP       = 'h0F27F,
  parameter int PER_A_BASE    = 'h0F800,
  parameter int PER_A_TOP     = 'h0FAFF,
  parameter int PER_B_BASE    = 'h0FC00,
  parameter int PER_B_TOP     = 'h0FFFF
) (
  input  logic [ADDR_W-1:0] addr_i,
  output zone_e             zone_o
);

  localparam int NUM_WIN = 6;
  localparam int AW1     = ADDR_W + 1;

  // Window table: base, top and resulting zone; earlier entries win.
  logic [AW1-1:0] win_base [NUM_WIN];
  logic [AW1-1:0] win_top  [NUM_WIN];
  zone_e          win_zone [NUM_WIN];
  logic [NUM_WIN-1:0] win_hit;

  assign win_base[0] = AW1'(FLASH_LO_BASE); assign win_top[0] = AW1'(FLASH_LO_TOP); assign win_zone[0] = ZN_FLASH;
  assign win_base[1] = AW1'(FLASH_HI_BASE); assign win_top[1] = AW1'(FLASH_HI_TOP); assign win_zone[1] = ZN_FLASH;
  assign win_base[2] = AW1'(RAM_BASE);      assign win_top[2] = AW1'(RAM_TOP);      assign win_zone[2] = ZN_RAM;
  assign win_base[3] = AW1'(EEP_BASE);      assign win_top[3] = AW1'(EEP_TOP);      assign win_zone[3] = ZN_EEP;
  assign win_base[4] = AW1'(PER_A_BASE);    assign win_top[4] = AW1'(PER_A_TOP);    assign win_zone[4] = ZN_PERIPH;
  assign win_base[5] = AW1'(PER_B_BASE);    assign win_top[5] = AW1'(PER_B_TOP);    assign win_zone[5] = ZN_PERIPH;

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    assign win_hit[g] = ({1'b0, addr_i} >= win_base[g]) && ({1'b0, addr_i} <= win_top[g]);
  end

  always_comb begin
    zone_o = ZN_UNMAPPED;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (win_hit[i]) zone_o = win_zone[i];
    end
  end

endmodule

// File: rtl/bct_timing_calc.sv
module bct_timing_calc
  import bct_pkg::*;
#(
  parameter int WAIT_W = 3,
  parameter int HOLD_W = 2,
  parameter int CNT_W  = WAIT_W + 1
) (
  input  zone_e             zone_i,
  input  logic              wr_i,
  input  logic [WAIT_W-1:0] cfg_wait_i,
  input  logic [HOLD_W-1:0] cfg_hold_i,
  input  logic              cfg_fast_rd_i,
  input  logic              cfg_post_idle_i,
  input  logic              cfg_pre_idle_i,
  input  logic              cfg_early_wr_i,
  input  logic              cfg_eep_zero_ws_i,
  input  logic              zone_diff_i,
  input  logic              prev_post_i,
  output logic [CNT_W-1:0]  wait_n_o,
  output logic [HOLD_W-1:0] hold_n_o,
  output logic [1:0]        gap_n_o,
  output logic              post_flag_o
);

  logic [CNT_W-1:0] flash_wait_base;
  logic             pre_gap;
  logic             post_gap;

  assign flash_wait_base = CNT_W'(cfg_wait_i) + CNT_W'(1);

  always_comb begin
    wait_n_o = '0;
    hold_n_o = '0;
    pre_gap  = 1'b0;
    unique case (zone_i)
      ZN_FLASH: begin
        pre_gap = cfg_pre_idle_i & zone_diff_i;
        if (cfg_fast_rd_i) begin
          wait_n_o = wr_i ? CNT_W'(1) : '0;
        end else begin
          wait_n_o = flash_wait_base + ((wr_i && cfg_early_wr_i) ? CNT_W'(1) : CNT_W'(0));
          hold_n_o = cfg_hold_i;
        end
      end
      ZN_EEP:    wait_n_o = cfg_eep_zero_ws_i ? '0 : CNT_W'(1);
      ZN_PERIPH: begin
        wait_n_o = CNT_W'(1);
        pre_gap  = 1'b1;
      end
      default: ;
    endcase
  end

  assign post_gap    = prev_post_i & zone_diff_i;
  assign gap_n_o     = {1'b0, post_gap} + {1'b0, pre_gap};
  assign post_flag_o = (zone_i == ZN_FLASH) & cfg_post_idle_i;

endmodule

// File: rtl/bct_zone_tracker.sv
module bct_zone_tracker
  import bct_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  accept_i,
  input  zone_e cur_zone_i,
  input  logic  cur_post_i,
  output logic  zone_diff_o,
  output logic  prev_post_o
);

  zone_e prev_zone_q, prev_zone_d;
  logic  prev_post_q, prev_post_d;

  always_comb begin
    prev_zone_d = prev_zone_q;
    prev_post_d = prev_post_q;
    if (accept_i) begin
      prev_zone_d = cur_zone_i;
      prev_post_d = cur_post_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_zone_q <= ZN_NONE;
      prev_post_q <= 1'b0;
    end else begin
      prev_zone_q <= prev_zone_d;
      prev_post_q <= prev_post_d;
    end
  end

  assign zone_diff_o = (prev_zone_q != ZN_NONE) && (prev_zone_q != cur_zone_i);
  assign prev_post_o = prev_post_q;

  // R11: an accepted access always becomes the recorded previous zone
  p_prev_tracks_r11: assert property (@(posedge clk) disable iff (!rst_n)
    accept_i |=> (prev_zone_q == $past(cur_zone_i)));

endmodule

// File: rtl/bct_sequencer.sv
module bct_sequencer
  import bct_pkg::*;
#(
  parameter int HOLD_W = 2,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [1:0]        gap_n_i,
  input  logic [CNT_W-1:0]  wait_n_i,
  input  logic [HOLD_W-1:0] hold_n_i,
  output logic              accept_o,
  output logic              busy_o,
  output logic              ph_idle_o,
  output logic              ph_access_o,
  output logic              ph_wait_o,
  output logic              ph_hold_o
);

  phase_e            state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CNT_W-1:0]  wait_q, wait_d;
  logic [HOLD_W-1:0] hold_q, hold_d;
  logic              load_en;

  assign accept_o = req_i && (state_q == PH_READY);
  assign load_en  = accept_o;

  always_comb begin
    wait_d = wait_q;
    hold_d = hold_q;
    if (load_en) begin
      wait_d = wait_n_i;
      hold_d = hold_n_i;
    end
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      PH_READY: begin
        if (accept_o) begin
          if (gap_n_i != 2'd0) begin
            state_d = PH_GAP;
            cnt_d   = CNT_W'(gap_n_i) - CNT_W'(1);
          end else begin
            state_d = PH_ACCESS;
          end
        end
      end
      PH_GAP: begin
        if (cnt_q == '0) state_d = PH_ACCESS;
        else             cnt_d   = cnt_q - CNT_W'(1);
      end
      PH_ACCESS: begin
        if (wait_q != '0) begin
          state_d = PH_WAIT;
          cnt_d   = wait_q - CNT_W'(1);
        end else if (hold_q != '0) begin
          state_d = PH_HOLD;
          cnt_d   = CNT_W'(hold_q) - CNT_W'(1);
        end else begin
          state_d = PH_READY;
        end
      end
      PH_WAIT: begin
        if (cnt_q != '0) begin
          cnt_d = cnt_q - CNT_W'(1);
        end else if (hold_q != '0) begin
          state_d = PH_HOLD;
          cnt_d   = CNT_W'(hold_q) - CNT_W'(1);
        end else begin
          state_d = PH_READY;
        end
      end
      PH_HOLD: begin
        if (cnt_q == '0) state_d = PH_READY;
        else             cnt_d   = cnt_q - CNT_W'(1);
      end
      default: state_d = PH_READY;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_READY;
      cnt_q   <= '0;
      wait_q  <= '0;
      hold_q  <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      wait_q  <= wait_d;
      hold_q  <= hold_d;
    end
  end

  assign busy_o      = (state_q != PH_READY);
  assign ph_idle_o   = (state_q == PH_GAP);
  assign ph_access_o = (state_q == PH_ACCESS);
  assign ph_wait_o   = (state_q == PH_WAIT);
  assign ph_hold_o   = (state_q == PH_HOLD);

  // R12: an accepted request makes the controller busy on the next cycle
  p_accept_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !busy_o) |=> busy_o);

  // R12: wait cycles only follow the access cycle or another wait
  p_wait_order_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ph_wait_o |-> $past(ph_access_o || ph_wait_o));

  // R12: hold cycles never precede the access cycle
  p_hold_order_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ph_hold_o |-> $past(ph_access_o || ph_wait_o || ph_hold_o));

  // R12: one access cycle per bus cycle
  p_access_once_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ph_access_o |=> !ph_access_o);

endmodule

// File: rtl/bct_bus_timer.sv
module bct_bus_timer
  import bct_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int WAIT_W = 3,
  parameter int HOLD_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [WAIT_W-1:0] cfg_wait_i,
  input  logic [HOLD_W-1:0] cfg_hold_i,
  input  logic              cfg_fast_rd_i,
  input  logic              cfg_post_idle_i,
  input  logic              cfg_pre_idle_i,
  input  logic              cfg_early_wr_i,
  input  logic              cfg_eep_zero_ws_i,
  output logic              busy_o,
  output logic              ph_idle_o,
  output logic              ph_access_o,
  output logic              ph_wait_o,
  output logic              ph_hold_o,
  output logic [2:0]        zone_o
);

  localparam int CNT_W = WAIT_W + 1;

  zone_e             dec_zone;
  zone_e             zone_q, zone_d;
  logic              zone_diff;
  logic              prev_post;
  logic              post_flag;
  logic              accept;
  logic [CNT_W-1:0]  wait_n;
  logic [HOLD_W-1:0] hold_n;
  logic [1:0]        gap_n;

  bct_zone_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr_i (addr_i),
    .zone_o (dec_zone)
  );

  bct_zone_tracker u_tracker (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept_i    (accept),
    .cur_zone_i  (dec_zone),
    .cur_post_i  (post_flag),
    .zone_diff_o (zone_diff),
    .prev_post_o (prev_post)
  );

  bct_timing_calc #(.WAIT_W(WAIT_W), .HOLD_W(HOLD_W), .CNT_W(CNT_W)) u_calc (
    .zone_i            (dec_zone),
    .wr_i              (wr_i),
    .cfg_wait_i        (cfg_wait_i),
    .cfg_hold_i        (cfg_hold_i),
    .cfg_fast_rd_i     (cfg_fast_rd_i),
    .cfg_post_idle_i   (cfg_post_idle_i),
    .cfg_pre_idle_i    (cfg_pre_idle_i),
    .cfg_early_wr_i    (cfg_early_wr_i),
    .cfg_eep_zero_ws_i (cfg_eep_zero_ws_i),
    .zone_diff_i       (zone_diff),
    .prev_post_i       (prev_post),
    .wait_n_o          (wait_n),
    .hold_n_o          (hold_n),
    .gap_n_o           (gap_n),
    .post_flag_o       (post_flag)
  );

  bct_sequencer #(.HOLD_W(HOLD_W), .CNT_W(CNT_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (req_i),
    .gap_n_i     (gap_n),
    .wait_n_i    (wait_n),
    .hold_n_i    (hold_n),
    .accept_o    (accept),
    .busy_o      (busy_o),
    .ph_idle_o   (ph_idle_o),
    .ph_access_o (ph_access_o),
    .ph_wait_o   (ph_wait_o),
    .ph_hold_o   (ph_hold_o)
  );

  always_comb begin
    zone_d = zone_q;
    if (accept) zone_d = dec_zone;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) zone_q <= ZN_NONE;
    else        zone_q <= zone_d;
  end

  assign zone_o = zone_q;

  // R12: the reported zone does not move during one bus cycle
  p_zone_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(zone_o));

  // R6: RAM never gets wait or hold cycles
  p_ram_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_zone == ZN_RAM) |-> (wait_n == '0 && hold_n == '0));

  // R7: data EEPROM uses at most one wait and no hold
  p_eep_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_zone == ZN_EEP) |-> (wait_n <= CNT_W'(1) && hold_n == '0));

  // R3: fast flash reads carry no wait and no hold
  p_fast_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_zone == ZN_FLASH && cfg_fast_rd_i && !wr_i) |-> (wait_n == '0 && hold_n == '0));

endmodule

// File: tb/bct_bus_timer_bench.sv
`timescale 1ns/1ps
module bct_bus_timer_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req;
  logic [16:0] addr;
  logic        wr;
  logic [2:0]  c_wait;
  logic [1:0]  c_hold;
  logic        c_fast, c_post, c_pre, c_early, c_zws;
  logic        busy, ph_idle, ph_acc, ph_wait, ph_hold;
  logic [2:0]  zone;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  bct_bus_timer u_bct_bus_timer (
    .clk (clk), .rst_n (rst_n), .req_i (req), .addr_i (addr), .wr_i (wr),
    .cfg_wait_i (c_wait), .cfg_hold_i (c_hold), .cfg_fast_rd_i (c_fast),
    .cfg_post_idle_i (c_post), .cfg_pre_idle_i (c_pre), .cfg_early_wr_i (c_early),
    .cfg_eep_zero_ws_i (c_zws), .busy_o (busy), .ph_idle_o (ph_idle),
    .ph_access_o (ph_acc), .ph_wait_o (ph_wait), .ph_hold_o (ph_hold), .zone_o (zone)
  );

  task automatic check(input bit ok, input string rq, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s", rq, msg);
    end
  endtask

  task automatic set_cfg(input int w, input int h, input bit f, input bit po,
                         input bit pr, input bit e, input bit z);
    c_wait = 3'(w); c_hold = 2'(h); c_fast = f; c_post = po;
    c_pre = pr; c_early = e; c_zws = z;
  endtask

  // One bus cycle: tally phases until busy falls, compare with expectations.
  task automatic run_access(input logic [16:0] a, input bit w, input int ez,
                            input int ei, input int ew, input int eh,
                            input bit inject, input string rq);
    int ni = 0, na = 0, nw = 0, nh = 0, n = 0, last_rank = 0;
    bit bad_order = 0, late_busy = 0;
    logic [2:0] zseen = '0;
    @(negedge clk);
    req = 1'b1; addr = a; wr = w;
    @(negedge clk);
    req = 1'b0;
    zseen = zone;
    while (busy && n < 40) begin
      int rank;
      if ((ph_idle + ph_acc + ph_wait + ph_hold) != 1) bad_order = 1;
      rank = ph_idle ? 0 : ph_acc ? 1 : ph_wait ? 2 : 3;
      if (rank < last_rank) bad_order = 1;
      last_rank = rank;
      ni += ph_idle; na += ph_acc; nw += ph_wait; nh += ph_hold;
      if (zone != zseen) bad_order = 1;
      n++;
      if (inject && n == 1) begin
        req = 1'b1; addr = 17'h0E000; wr = 1'b0;
      end else begin
        req = 1'b0;
      end
      @(negedge clk);
    end
    req = 1'b0;
    if (inject) begin
      @(negedge clk);
      late_busy = busy;
    end
    check(zseen == 3'(ez), rq, $sformatf("addr %h zone act=%0d exp=%0d", a, zseen, ez));
    check(ni == ei && na == 1 && nw == ew && nh == eh && !bad_order && !late_busy, rq,
          $sformatf("addr %h idle/acc/wait/hold act=%0d/%0d/%0d/%0d order_bad=%0d late_busy=%0d exp=%0d/1/%0d/%0d 0 0",
                    a, ni, na, nw, nh, bad_order, late_busy, ei, ew, eh));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete act=hung exp=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req = 1'b0; addr = '0; wr = 1'b0;
    set_cfg(3, 2, 0, 0, 1, 0, 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!busy && !ph_idle && !ph_acc && !ph_wait && !ph_hold && zone == 3'd0, "R13",
          $sformatf("in reset busy=%0d zone=%0d exp busy=0 zone=0", busy, zone));
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && zone == 3'd0, "R13",
          $sformatf("after reset busy=%0d zone=%0d exp 0 0", busy, zone));

    // R13/R2: first access after reset, normal flash read, pre-idle set
    run_access(17'h01234, 0, 1, 0, 4, 2, 0, "R13_R2");
    // R1/R9: high flash window, same zone, no idle
    set_cfg(0, 0, 0, 0, 1, 0, 0);
    run_access(17'h1C010, 0, 1, 0, 1, 0, 0, "R1_R9");
    run_access(17'h0BFFF, 0, 1, 0, 1, 0, 0, "R1");
    // R6: RAM ignores configuration
    set_cfg(7, 3, 0, 0, 1, 1, 0);
    run_access(17'h0E100, 0, 2, 0, 0, 0, 0, "R6");
    run_access(17'h0EFFF, 1, 2, 0, 0, 0, 0, "R6");
    // R9/R5: late write after zone change
    set_cfg(2, 1, 0, 0, 1, 0, 0);
    run_access(17'h00100, 1, 1, 1, 3, 1, 0, "R9_R5");
    // R5: early write, same zone; this access requests a trailing idle
    set_cfg(2, 1, 0, 1, 1, 1, 0);
    run_access(17'h00200, 1, 1, 0, 4, 1, 0, "R5");
    // R10/R7: EEPROM after flash with post-idle, one wait
    set_cfg(2, 1, 0, 0, 1, 0, 0);
    run_access(17'h0F27F, 0, 3, 1, 1, 0, 0, "R10_R7");
    // R7: zero-wait EEPROM
    set_cfg(2, 1, 0, 0, 1, 0, 1);
    run_access(17'h0F000, 1, 3, 0, 0, 0, 0, "R7");
    // R8: peripherals always take idle + wait
    run_access(17'h0F800, 0, 4, 1, 1, 0, 0, "R8");
    run_access(17'h0FFFF, 1, 4, 1, 1, 0, 0, "R8");
    run_access(17'h0FC00, 0, 4, 1, 1, 0, 0, "R8");
    // R11: unmapped addresses are single cycle and update previous zone
    set_cfg(0, 0, 0, 0, 1, 0, 0);
    run_access(17'h0FB00, 0, 5, 0, 0, 0, 0, "R11");
    run_access(17'h01000, 0, 1, 1, 1, 0, 0, "R11");
    run_access(17'h0C000, 1, 5, 0, 0, 0, 0, "R11");
    run_access(17'h0F280, 0, 5, 0, 0, 0, 0, "R11");
    run_access(17'h01000, 0, 1, 1, 1, 0, 0, "R11");
    // R3/R4: fast read ignores wait/hold; fast write takes one wait
    set_cfg(7, 3, 1, 0, 1, 1, 0);
    run_access(17'h1FFFF, 0, 1, 0, 0, 0, 0, "R3");
    run_access(17'h00000, 1, 1, 0, 1, 0, 0, "R4");
    // R10: trailing idle adds to peripheral leading idle
    set_cfg(0, 0, 0, 1, 1, 0, 0);
    run_access(17'h00010, 0, 1, 0, 1, 0, 0, "R10");
    run_access(17'h0F900, 0, 4, 2, 1, 0, 0, "R10");
    run_access(17'h00020, 0, 1, 1, 1, 0, 0, "R9");
    run_access(17'h00030, 0, 1, 0, 1, 0, 0, "R10");
    set_cfg(0, 0, 0, 1, 0, 0, 0);
    run_access(17'h0E010, 0, 2, 1, 0, 0, 0, "R10");
    // R12: a request during busy is ignored
    set_cfg(3, 1, 0, 0, 0, 0, 0);
    run_access(17'h00040, 0, 1, 0, 4, 1, 1, "R12");

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule